// File: doc/BRIEF.md
# Load-Supply Fault Monitor with Programmable Debounce

This block watches two already-resolved comparator flags that report the load supply as too low or too high. While either flag is asserted, a counter advances on each pulse of a slow time-base tick. If the fault lasts for a programmed number of ticks, the block latches a sticky supply-fail flag and forces every load output off. The delay comes from a parameter pair for each fault kind, and a single select input picks the long or the short member of the pair.

Recovery is asymmetric on purpose. The output-off request drops in the same cycle that both comparator flags go low, with no delay. The fail flag stays set until a status-clear pulse arrives. If the fault is still present and already timed out when the clear arrives, the flag returns on the next tick. A fault that drops before its delay has run out leaves no trace, and the counter starts again from zero on the next fault.

Top module: `supply_fail_monitor`

## Requirements
- R1: While reset is asserted and after its release, `fail_flag_o` and `out_off_o` are 0 until a fault has timed out.
- R2: The counter advances only on cycles where `tick_i` is 1 and `uv_i` or `ov_i` is 1. A cycle with both flags at 0 clears it. A fault that lasts fewer ticks than its limit sets nothing, and a later fault counts again from zero.
- R3: With only `ov_i` high, the fault times out on the OV_TICKS_LONG-th tick when `long_delay_i` is 1, and on the OV_TICKS_SHORT-th tick when it is 0.
- R4: With only `uv_i` high, the fault times out on the UV_TICKS_LONG-th tick when `long_delay_i` is 1, and on the UV_TICKS_SHORT-th tick when it is 0.
- R5: When `ov_i` is high, the overvoltage limit applies whatever the value of `uv_i`.
- R6: On the clock edge that samples the timing-out tick, `fail_flag_o` and `out_off_o` both go to 1.
- R7: `out_off_o` falls to 0 combinationally in the same cycle that `uv_i` and `ov_i` are both 0.
- R8: `fail_flag_o` stays 1 after recovery. A `status_clr_i` pulse clears it at the next edge.
- R9: A clear that arrives while a timed-out fault persists drops `fail_flag_o`. The flag is set again at the edge of the next tick, and `out_off_o` stays 1 throughout.
- R10: When a setting tick and `status_clr_i` arrive in the same cycle, the set wins.
- R11: Ticks with no fault present, and clears with no flag set, change neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_i | input | 1 | Supply-too-low comparator flag |
| ov_i | input | 1 | Supply-too-high comparator flag |
| tick_i | input | 1 | Single-cycle time-base pulse |
| long_delay_i | input | 1 | 1 selects the long delay, 0 the short delay |
| status_clr_i | input | 1 | Single-cycle status-clear request |
| fail_flag_o | output | 1 | Sticky supply-fail flag |
| out_off_o | output | 1 | Request to disable all load outputs |

## Verification
The bench goes after the exact tick on which each of the four limits times out. A design that is off by one would raise the flag a tick early or a tick late. It checks that a glitch shorter than the limit leaves no partial count behind; a design that keeps the count would later time out too soon. It checks that `ov_i` takes priority when both flags are set, and that the output-off request drops in the cycle of recovery rather than one cycle later. It also checks that a clear during a persisting fault is overridden at the next tick, and that a set and a clear arriving together leave the flag set; a design with the wrong priority would leave the flag low.

// File: rtl/supply_fail_monitor.sv
module supply_fail_monitor #(
  parameter int unsigned OV_TICKS_LONG  = 448,
  parameter int unsigned OV_TICKS_SHORT = 112,
  parameter int unsigned UV_TICKS_LONG  = 448,
  parameter int unsigned UV_TICKS_SHORT = 224
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_i,
  input  logic ov_i,
  input  logic tick_i,
  input  logic long_delay_i,
  input  logic status_clr_i,
  output logic fail_flag_o,
  output logic out_off_o
);

  localparam int unsigned OV_MAX = (OV_TICKS_LONG > OV_TICKS_SHORT) ? OV_TICKS_LONG : OV_TICKS_SHORT;
  localparam int unsigned UV_MAX = (UV_TICKS_LONG > UV_TICKS_SHORT) ? UV_TICKS_LONG : UV_TICKS_SHORT;
  localparam int unsigned MAX_TICKS = (OV_MAX > UV_MAX) ? OV_MAX : UV_MAX;
  localparam int unsigned CNT_W = $clog2(MAX_TICKS + 1);

  logic             fault;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             reach;
  logic             expired_q;
  logic             set_fail;

  assign fault   = uv_i | ov_i;
  assign limit   = ov_i ? (long_delay_i ? CNT_W'(OV_TICKS_LONG) : CNT_W'(OV_TICKS_SHORT))
                        : (long_delay_i ? CNT_W'(UV_TICKS_LONG) : CNT_W'(UV_TICKS_SHORT));
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign reach   = cnt_inc >= {1'b0, limit};
  assign set_fail = tick_i & fault & (expired_q | reach);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (!fault) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (tick_i && !expired_q) begin
      if (reach) expired_q <= 1'b1;
      else       cnt_q     <= cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            fail_flag_o <= 1'b0;
    else if (set_fail)     fail_flag_o <= 1'b1;
    else if (status_clr_i) fail_flag_o <= 1'b0;
  end

  assign out_off_o = expired_q & fault;

  a_r6_flag_with_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_off_o) |-> fail_flag_o);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag_o && !status_clr_i |=> fail_flag_o);

  a_r8_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_flag_o) |-> $past(status_clr_i));

  a_r2_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_flag_o) |-> $past(tick_i) && $past(uv_i || ov_i));

  a_r9_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_off_o |=> out_off_o || !(uv_i || ov_i));

endmodule

// File: tb/supply_fail_monitor_test.sv
module supply_fail_monitor_test;
  localparam int OVL = 6, OVS = 3, UVL = 5, UVS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic uv = 1'b0, ov = 1'b0, tick = 1'b0, sct = 1'b0, clr = 1'b0;
  logic flag, off;

  int checks = 0, fails = 0, cyc = 0;
  string req = "R1";
  int m_cnt = 0;
  bit m_exp = 0, m_flag = 0;

  supply_fail_monitor #(.OV_TICKS_LONG(OVL), .OV_TICKS_SHORT(OVS),
                        .UV_TICKS_LONG(UVL), .UV_TICKS_SHORT(UVS)) uut (
    .clk(clk), .rst_n(rst_n), .uv_i(uv), .ov_i(ov), .tick_i(tick),
    .long_delay_i(sct), .status_clr_i(clr), .fail_flag_o(flag), .out_off_o(off));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    int lim;
    bit set;
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_exp = 0; m_flag = 0;
    end else begin
      lim = ov ? (sct ? OVL : OVS) : (sct ? UVL : UVS);
      set = 0;
      if (!(uv || ov)) begin
        m_cnt = 0; m_exp = 0;
      end else if (tick) begin
        if (m_exp) set = 1;
        else begin
          m_cnt++;
          if (m_cnt >= lim) begin m_exp = 1; set = 1; end
        end
      end
      if (clr) m_flag = 0;
      if (set) m_flag = 1;
    end
  end

  always @(negedge clk) begin
    bit eo;
    eo = m_exp && (uv || ov);
    checks++;
    if (flag !== m_flag || off !== eo) begin
      fails++;
      $display("FAIL %s: flag=%b off=%b expected flag=%b off=%b at cycle %0d",
               req, flag, off, m_flag, eo, cyc);
    end
  end

  always @(posedge clk) if (cyc > 100000) begin
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(1);
      tick = 1'b0; step(2);
    end
  endtask

  task automatic expect_now(string r, bit f, bit o);
    checks++;
    if (flag !== f || off !== o) begin
      fails++;
      $display("FAIL %s: flag=%b off=%b expected flag=%b off=%b", r, flag, off, f, o);
    end
  endtask

  task automatic pulse_clr();
    clr = 1'b1; step(1); clr = 1'b0;
  endtask

  initial begin
    req = "R1"; step(3);
    expect_now("R1", 0, 0);
    rst_n = 1'b1; step(2);
    expect_now("R1", 0, 0);

    req = "R11"; ticks(4); pulse_clr(); step(2);
    expect_now("R11", 0, 0);

    req = "R2"; sct = 1'b0;
    uv = 1'b1; ticks(1); uv = 1'b0; step(1);
    uv = 1'b1; ticks(1); uv = 1'b0; step(1);
    expect_now("R2", 0, 0);
    ov = 1'b1; ticks(2); ov = 1'b0; step(1);
    ov = 1'b1; ticks(2); ov = 1'b0; step(1);
    expect_now("R2", 0, 0);

    req = "R4"; sct = 1'b0; uv = 1'b1; ticks(1);
    expect_now("R4", 0, 0);
    ticks(1);
    expect_now("R6", 1, 1);
    req = "R7"; uv = 1'b0; #1;
    expect_now("R7", 1, 0);
    req = "R8"; step(3);
    expect_now("R8", 1, 0);
    pulse_clr(); step(1);
    expect_now("R8", 0, 0);

    req = "R4"; sct = 1'b1; uv = 1'b1; ticks(UVL - 1);
    expect_now("R4", 0, 0);
    ticks(1);
    expect_now("R4", 1, 1);
    uv = 1'b0; step(1); pulse_clr(); step(1);

    req = "R3"; sct = 1'b1; ov = 1'b1; ticks(OVL - 1);
    expect_now("R3", 0, 0);
    ticks(1);
    expect_now("R3", 1, 1);
    ov = 1'b0; step(1); pulse_clr();
    sct = 1'b0; ov = 1'b1; ticks(OVS - 1);
    expect_now("R3", 0, 0);
    ticks(1);
    expect_now("R3", 1, 1);

    req = "R9"; pulse_clr(); step(1);
    expect_now("R9", 0, 1);
    ticks(1);
    expect_now("R9", 1, 1);

    req = "R10"; tick = 1'b1; clr = 1'b1; step(1);
    tick = 1'b0; clr = 1'b0; step(1);
    expect_now("R10", 1, 1);
    ov = 1'b0; step(1); pulse_clr(); step(1);

    req = "R5"; sct = 1'b1; uv = 1'b1; ov = 1'b1; ticks(UVL);
    expect_now("R5", 0, 0);
    ticks(OVL - UVL);
    expect_now("R5", 1, 1);
    uv = 1'b0; ov = 1'b0; step(1); pulse_clr(); step(2);
    expect_now("R11", 0, 0);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule